// File: doc/BRIEF.md
# PHY Management Front End with Built-In PHY Register Model

This block lets a processor read and write the 16-bit registers of a PHY through a small set of 32-bit host registers. There is no external PHY and no serial management waveform. The PHY register set is held inside the block, in 32 entries of 16 bits. The block models the behaviour a driver relies on: identity values after reset, a reset bit that clears itself, auto-negotiation that finishes as soon as it is started, and a link-up input that is copied into the status bits of the PHY.

Software uses it in a fixed order. It writes the target PHY address and register index. It then writes 16-bit data to the control register to perform a PHY write, or writes 1 to bit 0 of the command register to perform a PHY read. After a read, it collects the result from the status register. Accesses that name a different PHY address have no effect on the model, and reads from such an address return zero.

Top module: `mdio_phy_emu`

## Requirements
- R1: After the synchronous reset, the address, control and status host registers read 0.
- R2: The address register (host select 0) keeps the PHY address in bits 12:8 and the register index in bits 4:0. All other bits read back as 0.
- R3: Writing to the command register (host select 2) with bit 0 set copies the selected PHY register into the status register (host select 3). A command with bit 0 clear has no effect. A host write to select 3 has no effect.
- R4: A write to the control register (host select 1) stores bits 15:0, which read back zero-extended. When the PHY address matches the PHY_ADDR parameter, the same data is written into the selected PHY register.
- R5: When the PHY address does not match, a control write leaves every PHY register unchanged, and a command read loads 0x0000 into the status register.
- R6: After reset, PHY registers 0 to 5 hold 0x1140, 0x7968, 0x0022, 0x1550, 0x01E1 and 0xCDE1, before the link bits are applied. Every other PHY register holds 0.
- R7: A PHY write to register 0 with bit 15 set reloads every PHY register with its reset value. Register 0 then takes the written data with bit 15 cleared.
- R8: A PHY write to register 0 with bit 12 set sets bit 5 of PHY register 1 and stores the data with bit 12 cleared.
- R9: Bits 5 and 2 of PHY register 1 are set to the level of link_up at every reset, including the reset in R7, and whenever link_up changes.
- R10: When link_up changes in the same cycle as a host access, the link update is applied first and a PHY write to register 1 then wins. A command read in that cycle returns the register contents from before the cycle.
- R11: rd_data shows the host register chosen by rd_sel one cycle later. Select 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link state copied into the PHY status bits |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register written: 0 address, 1 control, 2 command, 3 status |
| host_wdata | input | 32 | Host write data |
| rd_sel | input | 2 | Host register to read, same encoding as host_sel |
| rd_data | output | 32 | Registered read data, one cycle after rd_sel |

## Verification
Two things can happen in the same cycle: a change on link_up and a host access to the PHY model. The bench provokes this in two ways. It toggles link_up in the cycle that carries a command read of PHY register 1, and it toggles link_up in the cycle that carries a control write to PHY register 1. The first collision must return the status value from before the toggle, and a normal read afterwards must show the new link bits. The second collision must keep the written data. A behavioural model in the bench is also compared on every clock while random traffic mixes link toggles with all host accesses.

// File: rtl/mdio_emu_pkg.sv
package mdio_emu_pkg;
  localparam int PHY_DW = 16;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } host_sel_e;

  localparam int IDX_CTL  = 0;
  localparam int IDX_STS  = 1;
  localparam int CTL_RESET_BIT = 15;
  localparam int CTL_ANEN_BIT  = 12;
  localparam int STS_ANOK_BIT  = 5;
  localparam int STS_LINK_BIT  = 2;

  function automatic logic [PHY_DW-1:0] phy_default(input int idx);
    case (idx)
      0: return 16'h1140;
      1: return 16'h7968;
      2: return 16'h0022;
      3: return 16'h1550;
      4: return 16'h01E1;
      5: return 16'hCDE1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PHY_DW-1:0] apply_link(input logic [PHY_DW-1:0] v,
                                                   input logic up);
    logic [PHY_DW-1:0] r;
    r = v;
    r[STS_ANOK_BIT] = up;
    r[STS_LINK_BIT] = up;
    return r;
  endfunction
endpackage

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile
  import mdio_emu_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [PHY_DW-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [PHY_DW-1:0] rd_data,
  output logic [PHY_DW-1:0] ctl_o,
  output logic [PHY_DW-1:0] sts_o
);
  logic [PHY_DW-1:0] mem_q [NREG];
  logic [PHY_DW-1:0] mem_d [NREG];
  logic              link_q;

  always_comb begin
    logic [PHY_DW-1:0] wval;
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    if (link_up != link_q)
      mem_d[IDX_STS] = apply_link(mem_q[IDX_STS], link_up);
    wval = wr_data;
    if (wr_en && wr_idx == IW'(IDX_CTL)) begin
      if (wval[CTL_RESET_BIT]) begin
        for (int i = 0; i < NREG; i++) mem_d[i] = phy_default(i);
        mem_d[IDX_STS] = apply_link(phy_default(IDX_STS), link_up);
        wval[CTL_RESET_BIT] = 1'b0;
      end
      if (wval[CTL_ANEN_BIT]) begin
        wval[CTL_ANEN_BIT] = 1'b0;
        mem_d[IDX_STS][STS_ANOK_BIT] = 1'b1;
      end
    end
    if (wr_en) mem_d[wr_idx] = wval;
  end

  always_ff @(posedge clk) begin
    link_q <= link_up;
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        mem_q[i] <= (i == IDX_STS) ? apply_link(phy_default(i), link_up)
                                   : phy_default(i);
    end else begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign ctl_o   = mem_q[IDX_CTL];
  assign sts_o   = mem_q[IDX_STS];
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_emu_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd3,
  parameter int IW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              phy_wr_en,
  output logic [IW-1:0]     phy_idx,
  output logic [PHY_DW-1:0] phy_wdata,
  output logic [4:0]        phy_addr_f,
  input  logic [PHY_DW-1:0] phy_rdata
);
  logic [4:0]        paddr_q;
  logic [IW-1:0]     ridx_q;
  logic [PHY_DW-1:0] ctrl_q;
  logic [PHY_DW-1:0] stat_q;
  logic              addr_hit;

  assign addr_hit = (paddr_q == PHY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      paddr_q <= '0;
      ridx_q  <= '0;
      ctrl_q  <= '0;
      stat_q  <= '0;
      rd_data <= '0;
    end else begin
      if (host_wr) begin
        case (host_sel)
          SEL_ADDR: begin
            paddr_q <= host_wdata[12:8];
            ridx_q  <= host_wdata[IW-1:0];
          end
          SEL_CTRL: ctrl_q <= host_wdata[PHY_DW-1:0];
          SEL_CMD:  if (host_wdata[0]) stat_q <= addr_hit ? phy_rdata : '0;
          default: ;
        endcase
      end
      case (rd_sel)
        SEL_ADDR: rd_data <= {19'd0, paddr_q, 3'd0, 5'(ridx_q)};
        SEL_CTRL: rd_data <= {16'd0, ctrl_q};
        SEL_STAT: rd_data <= {16'd0, stat_q};
        default:  rd_data <= '0;
      endcase
    end
  end

  assign phy_wr_en  = host_wr && (host_sel == SEL_CTRL) && addr_hit;
  assign phy_idx    = ridx_q;
  assign phy_wdata  = host_wdata[PHY_DW-1:0];
  assign phy_addr_f = paddr_q;
endmodule

// File: rtl/mdio_phy_emu.sv
module mdio_phy_emu
  import mdio_emu_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd3,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        link_up,
  input  logic        host_wr,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data
);
  logic              phy_wr_en;
  logic [IW-1:0]     phy_idx;
  logic [PHY_DW-1:0] phy_wdata;
  logic [PHY_DW-1:0] phy_rdata;
  logic [4:0]        phy_addr_f;
  logic [PHY_DW-1:0] ctl_reg;
  logic [PHY_DW-1:0] sts_reg;

  mdio_host_regs #(.PHY_ADDR(PHY_ADDR), .IW(IW)) u_host (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .phy_wr_en(phy_wr_en), .phy_idx(phy_idx), .phy_wdata(phy_wdata),
    .phy_addr_f(phy_addr_f), .phy_rdata(phy_rdata)
  );

  mdio_phy_regfile #(.NREG(NREG)) u_phy (
    .clk(clk), .rst(rst), .link_up(link_up), .wr_en(phy_wr_en),
    .wr_idx(phy_idx), .wr_data(phy_wdata), .rd_idx(phy_idx),
    .rd_data(phy_rdata), .ctl_o(ctl_reg), .sts_o(sts_reg)
  );
endmodule

// File: rtl/mdio_phy_emu_chk.sv
module mdio_phy_emu_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd3,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          link_up,
  input logic          host_wr,
  input logic [1:0]    host_sel,
  input logic [1:0]    rd_sel,
  input logic [31:0]   rd_data,
  input logic          phy_wr_en,
  input logic [IW-1:0] phy_idx,
  input logic [15:0]   phy_wdata,
  input logic [4:0]    phy_addr_f,
  input logic [15:0]   ctl_reg,
  input logic [15:0]   sts_reg
);
  logic wr_ctl, wr_sts;
  assign wr_ctl = phy_wr_en && (phy_idx == '0);
  assign wr_sts = phy_wr_en && (phy_idx == IW'(1));

  assert_autoneg_R8: assert property (@(posedge clk) disable iff (rst)
    wr_ctl && phy_wdata[12] |=> !ctl_reg[12] && sts_reg[5]);

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ctl && phy_wdata[15] |=> !ctl_reg[15] && sts_reg[15:8] == 8'h79);

  assert_link_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    (link_up != $past(link_up)) && !wr_sts && !(wr_ctl && phy_wdata[12])
    |=> sts_reg[5] == $past(link_up) && sts_reg[2] == $past(link_up));

  assert_foreign_write_R5: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_sel == 2'd1 && phy_addr_f != PHY_ADDR && $stable(link_up)
    |=> $stable(ctl_reg) && $stable(sts_reg));

  assert_addr_fields_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel) == 2'd0 |-> rd_data[31:13] == '0 && rd_data[7:5] == '0);

  assert_cmd_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel) == 2'd2 |-> rd_data == '0);
endmodule

bind mdio_phy_emu mdio_phy_emu_chk #(.PHY_ADDR(PHY_ADDR), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .link_up(link_up), .host_wr(host_wr),
  .host_sel(host_sel), .rd_sel(rd_sel), .rd_data(rd_data),
  .phy_wr_en(phy_wr_en), .phy_idx(phy_idx), .phy_wdata(phy_wdata),
  .phy_addr_f(phy_addr_f), .ctl_reg(ctl_reg), .sts_reg(sts_reg)
);

// File: tb/tb_mdio_phy_emu.sv
`timescale 1ns/1ps
module tb_mdio_phy_emu;
  localparam logic [4:0] LOCAL = 5'd3;
  localparam logic [4:0] OTHER = 5'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdio_phy_emu #(.PHY_ADDR(LOCAL)) dut (
    .clk(clk), .rst(rst), .link_up(link_up), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  // behavioural reference model
  logic [15:0] m_phy [32];
  logic [4:0]  m_paddr, m_ridx;
  logic [15:0] m_ctrl, m_stat;
  logic        m_link;

  task automatic m_load_defaults();
    for (int i = 0; i < 32; i++) m_phy[i] = 16'h0000;
    m_phy[0] = 16'h1140; m_phy[1] = 16'h7968; m_phy[2] = 16'h0022;
    m_phy[3] = 16'h1550; m_phy[4] = 16'h01E1; m_phy[5] = 16'hCDE1;
    m_phy[1][5] = m_link; m_phy[1][2] = m_link;
  endtask

  task automatic m_phy_write(input logic [4:0] idx, input logic [15:0] d);
    logic [15:0] v;
    v = d;
    if (idx == 5'd0) begin
      if (v[15]) begin m_load_defaults(); v[15] = 1'b0; end
      if (v[12]) begin v[12] = 1'b0; m_phy[1][5] = 1'b1; end
    end
    m_phy[idx] = v;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                      input logic [1:0] rs, input bit lk, input string tag);
    logic [31:0] exp;
    logic [15:0] old_rd;
    host_wr = wr; host_sel = sel; host_wdata = wd; rd_sel = rs; link_up = lk;
    @(posedge clk);
    case (rs)
      2'd0: exp = {19'd0, m_paddr, 3'd0, m_ridx};
      2'd1: exp = {16'd0, m_ctrl};
      2'd3: exp = {16'd0, m_stat};
      default: exp = '0;
    endcase
    old_rd = (m_paddr == LOCAL) ? m_phy[m_ridx] : 16'h0000;
    if (lk != m_link) begin
      m_link = lk; m_phy[1][5] = lk; m_phy[1][2] = lk;
    end
    if (wr) begin
      case (sel)
        2'd0: begin m_paddr = wd[12:8]; m_ridx = wd[4:0]; end
        2'd1: begin
          m_ctrl = wd[15:0];
          if (m_paddr == LOCAL) m_phy_write(m_ridx, wd[15:0]);
        end
        2'd2: if (wd[0]) m_stat = old_rd;
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  bit cur_link = 1'b0;

  task automatic idle(input logic [1:0] rs, input string tag);
    step(1'b0, 2'd0, 32'd0, rs, cur_link, tag);
  endtask

  task automatic set_addr(input logic [4:0] pa, input logic [4:0] idx, input string tag);
    step(1'b1, 2'd0, {19'd0, pa, 3'd0, idx}, 2'd0, cur_link, tag);
  endtask

  task automatic phy_rd(input logic [4:0] pa, input logic [4:0] idx,
                        input logic [15:0] exp, input string tag);
    set_addr(pa, idx, tag);
    step(1'b1, 2'd2, 32'd1, 2'd3, cur_link, tag);
    idle(2'd3, tag);
    check(tag, rd_data, {16'd0, exp});
  endtask

  task automatic phy_wr(input logic [4:0] pa, input logic [4:0] idx,
                        input logic [31:0] d, input string tag);
    set_addr(pa, idx, tag);
    step(1'b1, 2'd1, d, 2'd1, cur_link, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_link = 1'b0; m_paddr = '0; m_ridx = '0; m_ctrl = '0; m_stat = '0;
    m_load_defaults();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    idle(2'd0, "R1"); idle(2'd1, "R1"); idle(2'd3, "R1"); check("R1", rd_data, 32'd0);
    // R6 defaults, R9 link down at reset
    phy_rd(LOCAL, 5'd0, 16'h1140, "R6");
    phy_rd(LOCAL, 5'd1, 16'h7948, "R9");
    phy_rd(LOCAL, 5'd2, 16'h0022, "R6");
    phy_rd(LOCAL, 5'd3, 16'h1550, "R6");
    phy_rd(LOCAL, 5'd4, 16'h01E1, "R6");
    phy_rd(LOCAL, 5'd5, 16'hCDE1, "R6");
    phy_rd(LOCAL, 5'd9, 16'h0000, "R6");
    // R9 link changes
    cur_link = 1'b1; idle(2'd3, "R9");
    phy_rd(LOCAL, 5'd1, 16'h796C, "R9");
    cur_link = 1'b0; idle(2'd3, "R9");
    phy_rd(LOCAL, 5'd1, 16'h7948, "R9");
    // R2 address field masking
    step(1'b1, 2'd0, 32'hFFFF_FFFF, 2'd0, cur_link, "R2");
    idle(2'd0, "R2"); check("R2", rd_data, 32'h0000_1F1F);
    // R4 write and read back
    phy_wr(LOCAL, 5'd4, 32'h1234_ABCD, "R4");
    idle(2'd1, "R4"); check("R4", rd_data, 32'h0000_ABCD);
    phy_rd(LOCAL, 5'd4, 16'hABCD, "R4");
    // R5 foreign address
    phy_wr(OTHER, 5'd4, 32'h0000_5555, "R5");
    phy_rd(OTHER, 5'd4, 16'h0000, "R5");
    phy_rd(LOCAL, 5'd4, 16'hABCD, "R5");
    // R3 command bit 0 clear and status write ignored
    step(1'b1, 2'd2, 32'h0000_0002, 2'd3, cur_link, "R3");
    step(1'b1, 2'd3, 32'h0000_FFFF, 2'd3, cur_link, "R3");
    idle(2'd3, "R3"); check("R3", rd_data, 32'h0000_ABCD);
    // R11 command register reads zero
    idle(2'd2, "R11"); check("R11", rd_data, 32'd0);
    // R8 auto-negotiation
    phy_wr(LOCAL, 5'd0, 32'h0000_1000, "R8");
    phy_rd(LOCAL, 5'd0, 16'h0000, "R8");
    phy_rd(LOCAL, 5'd1, 16'h7968, "R8");
    // R7 soft reset
    phy_wr(LOCAL, 5'd4, 32'h0000_1111, "R7");
    phy_wr(LOCAL, 5'd0, 32'h0000_8000, "R7");
    phy_rd(LOCAL, 5'd4, 16'h01E1, "R7");
    phy_rd(LOCAL, 5'd0, 16'h0000, "R7");
    phy_rd(LOCAL, 5'd1, 16'h7948, "R7");
    phy_wr(LOCAL, 5'd0, 32'h0000_9140, "R7");
    phy_rd(LOCAL, 5'd0, 16'h0140, "R7");
    phy_rd(LOCAL, 5'd1, 16'h7968, "R8");
    // R10 collisions
    cur_link = 1'b1; idle(2'd3, "R10");
    phy_wr(LOCAL, 5'd0, 32'h0000_8000, "R10");
    set_addr(LOCAL, 5'd1, "R10");
    cur_link = 1'b0;
    step(1'b1, 2'd2, 32'd1, 2'd3, cur_link, "R10");
    idle(2'd3, "R10"); check("R10", rd_data, 32'h0000_796C);
    phy_rd(LOCAL, 5'd1, 16'h7948, "R10");
    cur_link = 1'b1;
    step(1'b1, 2'd1, 32'h0000_0000, 2'd1, cur_link, "R10");
    phy_rd(LOCAL, 5'd1, 16'h0000, "R10");
    // random traffic compared against model every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r, wd;
      logic [1:0] sel;
      r = $urandom;
      sel = r[1:0];
      wd = $urandom;
      if (sel == 2'd0) wd = {19'd0, (r[4:2] == 3'd0) ? OTHER : LOCAL, 3'd0, 2'd0, r[7:5]};
      if (r[15:11] == 5'd0) cur_link = ~cur_link;
      step(r[8], sel, wd, r[10:9], cur_link, "R10");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule